// File: doc/BRIEF.md
# Mailbox Bootstrap Doorbell

This block lets a host issue a management command before any command rings have been created. It is the only path to the management processor at that point. The host writes one 32-bit register twice. The first write has the phase flag set and carries the upper part of the mailbox's physical address. The second write has the phase flag clear and carries the lower part. Once both halves are in, the block hands the joined line address to a command engine over a valid/ready request port.

Between writes, the host polls a single ready bit in the same register. Ready rises to acknowledge the upper half. It falls when the lower half starts the command. It rises again only when the engine's completion pulse says the mailbox now holds a valid completion entry. Writes that break this order are dropped, and they raise a sticky protocol-error output.

The mailbox is 16-byte aligned, so the two 30-bit halves form a 60-bit line address. The upper write supplies physical address bits 63:34 and the lower write supplies bits 33:4.

Top module: `mbox_boot_doorbell`

## Requirements
- R1: After reset, the read word is zero, no request is offered and the protocol-error output is low.
- R2: A write with bit 1 (phase flag) = 1 in the idle state latches bits 31:2 as the upper half. The read word's bit 0 (ready) is 1 from the following cycle, and no request is offered.
- R3: A write with bit 1 = 0 while the upper half is held does two things from the following cycle: ready goes to 0, and one request is offered with address = {upper bits 31:2, lower bits 31:2}, upper half in address bits 59:30.
- R4: An offered request keeps valid high and its address unchanged until a cycle where ready-in is high; valid is low after that handshake. Each command produces exactly one handshake.
- R5: After the lower write, ready stays 0 until a completion pulse arrives after the request was accepted. Ready is 1 from the cycle after that pulse.
- R6: A completion pulse is ignored in three cases: when no command is running, when it arrives while the request is still unaccepted, and when it arrives in the handshake cycle itself.
- R7: A write with bit 1 = 0 in the idle state, or after completion, changes neither ready nor the request port. It sets the protocol-error output.
- R8: A second write with bit 1 = 1 while the upper half is already held is dropped: the first upper half is kept. It sets the protocol-error output.
- R9: Any write while a command runs is dropped, with no new request and no change to ready. It sets the protocol-error output.
- R10: The protocol-error output stays high once set, until reset.
- R11: A write with bit 1 = 1 after completion starts a new command. Read-word bits 31:1 are always zero.
- R12: Bit 0 of a written word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Written word: bit 1 phase flag, bits 31:2 address half |
| reg_rd_data | output | 32 | Read word: bit 0 ready, other bits zero |
| cmd_req_valid | output | 1 | Request to the command engine is offered |
| cmd_req_ready | input | 1 | Command engine accepts the request |
| cmd_req_addr | output | 60 | Mailbox line address of the request |
| cmd_done | input | 1 | Single-cycle completion pulse from the engine |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The hardest situation to reach is a completion pulse arriving while the request is still waiting for its handshake. A correct engine never does this, yet the block must ignore it. The bench plays the engine itself, holding the request's ready-in low for a varying number of cycles and firing a stray completion pulse in that window. Each error case is reached from a fresh reset, because the sticky flag would otherwise hide which write raised it. The sweep runs commands back to back without reset so that the restart from the completed state is exercised every time.

// File: rtl/mbox_boot_pkg.sv
package mbox_boot_pkg;

    // Handshake phase of the doorbell. The encoding is internal only.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_UPPER   = 2'd1,
        PH_RUNNING = 2'd2,
        PH_FINISH  = 2'd3
    } mbox_phase_e;

    // Bit positions in the register word, fixed by the host interface.
    localparam int RDY_POS   = 0;
    localparam int PHASE_POS = 1;
    localparam int FIELD_LSB = 2;

    function automatic logic phase_shows_ready(mbox_phase_e ph);
        return (ph == PH_UPPER) || (ph == PH_FINISH);
    endfunction

endpackage

// File: rtl/mbox_wr_decode.sv
module mbox_wr_decode
    import mbox_boot_pkg::*;
#(
    parameter int DATA_W  = 32,
    localparam int FIELD_W = DATA_W - FIELD_LSB
) (
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               wr_upper,
    output logic               wr_lower,
    output logic [FIELD_W-1:0] wr_field
);

    // The ready position is read-only; a written value there is dropped.
    logic unused_rdy_bit;
    assign unused_rdy_bit = wr_data[RDY_POS];

    always_comb begin
        wr_upper = wr_en &&  wr_data[PHASE_POS];
        wr_lower = wr_en && !wr_data[PHASE_POS];
        wr_field = wr_data[DATA_W-1:FIELD_LSB];
    end

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
    import mbox_boot_pkg::*;
#(
    parameter int FIELD_W = 30,
    localparam int LINE_W = 2 * FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_upper,
    input  logic               wr_lower,
    input  logic [FIELD_W-1:0] wr_field,
    input  logic               req_pending,
    input  logic               cmd_done,
    output mbox_phase_e        phase,
    output logic               launch,
    output logic [LINE_W-1:0]  launch_addr,
    output logic               proto_err
);

    typedef struct packed {
        mbox_phase_e        ph;
        logic [FIELD_W-1:0] upper;
        logic               err;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      launch_d;

    always_comb begin
        seq_d    = seq_q;
        launch_d = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE, PH_FINISH: begin
                if (wr_upper) begin
                    seq_d.upper = wr_field;
                    seq_d.ph    = PH_UPPER;
                end else if (wr_lower) begin
                    seq_d.err = 1'b1;
                end
            end
            PH_UPPER: begin
                if (wr_lower) begin
                    seq_d.ph = PH_RUNNING;
                    launch_d = 1'b1;
                end else if (wr_upper) begin
                    seq_d.err = 1'b1;
                end
            end
            PH_RUNNING: begin
                if (wr_upper || wr_lower) begin
                    seq_d.err = 1'b1;
                end
                // Completion only counts once the request has left the port.
                if (cmd_done && !req_pending) begin
                    seq_d.ph = PH_FINISH;
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, upper: '0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase       = seq_q.ph;
    assign launch      = launch_d;
    assign launch_addr = {seq_q.upper, wr_field};
    assign proto_err   = seq_q.err;

endmodule

// File: rtl/mbox_req_stage.sv
module mbox_req_stage #(
    parameter int LINE_W = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [LINE_W-1:0] launch_addr,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [LINE_W-1:0] req_addr
);

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] addr;
    } req_regs_t;

    req_regs_t req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (launch) begin
            req_d.valid = 1'b1;
            req_d.addr  = launch_addr;
        end else if (req_q.valid && req_ready) begin
            req_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req_valid = req_q.valid;
    assign req_addr  = req_q.addr;

endmodule

// File: rtl/mbox_boot_doorbell.sv
module mbox_boot_doorbell
    import mbox_boot_pkg::*;
#(
    parameter int DATA_W  = 32,
    localparam int FIELD_W = DATA_W - FIELD_LSB,
    localparam int LINE_W  = 2 * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic              cmd_req_valid,
    input  logic              cmd_req_ready,
    output logic [LINE_W-1:0] cmd_req_addr,
    input  logic              cmd_done,
    output logic              proto_err
);

    logic               wr_upper;
    logic               wr_lower;
    logic [FIELD_W-1:0] wr_field;
    mbox_phase_e        phase;
    logic               launch;
    logic [LINE_W-1:0]  launch_addr;

    mbox_wr_decode #(.DATA_W(DATA_W)) u_decode (
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .wr_upper (wr_upper),
        .wr_lower (wr_lower),
        .wr_field (wr_field)
    );

    mbox_seq #(.FIELD_W(FIELD_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_upper    (wr_upper),
        .wr_lower    (wr_lower),
        .wr_field    (wr_field),
        .req_pending (cmd_req_valid),
        .cmd_done    (cmd_done),
        .phase       (phase),
        .launch      (launch),
        .launch_addr (launch_addr),
        .proto_err   (proto_err)
    );

    mbox_req_stage #(.LINE_W(LINE_W)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_addr (launch_addr),
        .req_ready   (cmd_req_ready),
        .req_valid   (cmd_req_valid),
        .req_addr    (cmd_req_addr)
    );

    always_comb begin
        reg_rd_data          = '0;
        reg_rd_data[RDY_POS] = phase_shows_ready(phase);
    end

endmodule

// File: rtl/mbox_boot_doorbell_chk.sv
module mbox_boot_doorbell_chk #(
    parameter int DATA_W = 32,
    parameter int LINE_W = 60
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] reg_rd_data,
    input logic              cmd_req_valid,
    input logic              cmd_req_ready,
    input logic [LINE_W-1:0] cmd_req_addr,
    input logic              proto_err
);

    // R4
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_valid && !cmd_req_ready |=> cmd_req_valid && $stable(cmd_req_addr));

    // R4
    single_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_valid && cmd_req_ready |=> !cmd_req_valid);

    // R5
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_valid |-> !reg_rd_data[0]);

    // R10
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R11
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[DATA_W-1:1] == '0);

endmodule

bind mbox_boot_doorbell mbox_boot_doorbell_chk #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_rd_data   (reg_rd_data),
    .cmd_req_valid (cmd_req_valid),
    .cmd_req_ready (cmd_req_ready),
    .cmd_req_addr  (cmd_req_addr),
    .proto_err     (proto_err)
);

// File: tb/mbox_boot_doorbell_test.sv
`timescale 1ns/1ps
module mbox_boot_doorbell_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        cmd_req_valid;
    logic        cmd_req_ready = 1'b0;
    logic [59:0] cmd_req_addr;
    logic        cmd_done = 1'b0;
    logic        proto_err;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    mbox_boot_doorbell uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_wr_data   (reg_wr_data),
        .reg_rd_data   (reg_rd_data),
        .cmd_req_valid (cmd_req_valid),
        .cmd_req_ready (cmd_req_ready),
        .cmd_req_addr  (cmd_req_addr),
        .cmd_done      (cmd_done),
        .proto_err     (proto_err)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(logic [29:0] field, logic phase, logic b0);
        reg_wr_en   = 1'b1;
        reg_wr_data = {field, phase, b0};
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic pulse_done();
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
    endtask

    task automatic accept();
        cmd_req_ready = 1'b1;
        @(negedge clk);
        cmd_req_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 rd", 64'(reg_rd_data), 64'd0);
        chk("R1 valid", 64'(cmd_req_valid), 64'd0);
        chk("R1 err", 64'(proto_err), 64'd0);

        // Sweep: back-to-back commands with walking address bits and varied delays
        for (int i = 0; i < 30; i++) begin
            logic [29:0] hv;
            logic [29:0] lv;
            hv = 30'd1 << i;
            lv = ~hv ^ 30'(i * 7);
            wr(hv, 1'b1, i[0]);                     // R12: bit 0 varies
            chk("R2 R11 rd", 64'(reg_rd_data), 64'd1);
            chk("R2 valid", 64'(cmd_req_valid), 64'd0);
            wr(lv, 1'b0, i[1]);
            chk("R3 rd", 64'(reg_rd_data), 64'd0);
            chk("R3 valid", 64'(cmd_req_valid), 64'd1);
            chk("R3 R12 addr", 64'(cmd_req_addr), 64'({hv, lv}));
            for (int k = 0; k < (i % 4); k++) begin
                if (k == 0) pulse_done();            // R6 stray completion
                else @(negedge clk);
                chk("R6 rd", 64'(reg_rd_data), 64'd0);
                chk("R4 valid", 64'(cmd_req_valid), 64'd1);
                chk("R4 addr", 64'(cmd_req_addr), 64'({hv, lv}));
            end
            accept();
            chk("R4 drop", 64'(cmd_req_valid), 64'd0);
            for (int k = 0; k < (i % 3); k++) begin
                @(negedge clk);
                chk("R5 wait", 64'(reg_rd_data), 64'd0);
            end
            pulse_done();
            chk("R5 done", 64'(reg_rd_data), 64'd1);
        end
        chk("R10 no err", 64'(proto_err), 64'd0);

        // R7: lower write after completion is dropped
        wr(30'h155, 1'b0, 1'b0);
        chk("R7 rd", 64'(reg_rd_data), 64'd1);
        chk("R7 valid", 64'(cmd_req_valid), 64'd0);
        chk("R7 err", 64'(proto_err), 64'd1);

        // R7: lower write in idle
        do_reset();
        wr(30'h2AA, 1'b0, 1'b1);
        chk("R7 idle rd", 64'(reg_rd_data), 64'd0);
        chk("R7 idle valid", 64'(cmd_req_valid), 64'd0);
        chk("R7 idle err", 64'(proto_err), 64'd1);

        // R10: error stays through a good command, reset clears it
        wr(30'h1, 1'b1, 1'b0);
        wr(30'h2, 1'b0, 1'b0);
        accept();
        pulse_done();
        chk("R10 sticky", 64'(proto_err), 64'd1);
        do_reset();
        chk("R10 cleared", 64'(proto_err), 64'd0);

        // R8: repeated upper write keeps the first one
        wr(30'h0ABCDEF, 1'b1, 1'b0);
        wr(30'h3FFFFFF, 1'b1, 1'b0);
        chk("R8 err", 64'(proto_err), 64'd1);
        chk("R8 rd", 64'(reg_rd_data), 64'd1);
        wr(30'h1234567, 1'b0, 1'b0);
        chk("R8 addr", 64'(cmd_req_addr), 64'({30'h0ABCDEF, 30'h1234567}));
        accept();
        pulse_done();

        // R9: writes while running are dropped
        do_reset();
        wr(30'h11, 1'b1, 1'b0);
        wr(30'h22, 1'b0, 1'b0);
        accept();
        wr(30'h33, 1'b1, 1'b0);
        chk("R9 err", 64'(proto_err), 64'd1);
        chk("R9 rd", 64'(reg_rd_data), 64'd0);
        wr(30'h44, 1'b0, 1'b0);
        chk("R9 valid", 64'(cmd_req_valid), 64'd0);
        chk("R9 rd2", 64'(reg_rd_data), 64'd0);
        pulse_done();
        chk("R9 done", 64'(reg_rd_data), 64'd1);

        // R6: completion in idle and in upper-held state ignored; same-cycle handshake ignored
        do_reset();
        pulse_done();
        chk("R6 idle", 64'(reg_rd_data), 64'd0);
        wr(30'h5, 1'b1, 1'b0);
        pulse_done();
        chk("R6 upper rd", 64'(reg_rd_data), 64'd1);
        wr(30'h6, 1'b0, 1'b0);
        chk("R6 launch", 64'(cmd_req_addr), 64'({30'h5, 30'h6}));
        cmd_done = 1'b1;
        accept();
        cmd_done = 1'b0;
        chk("R6 same cycle", 64'(reg_rd_data), 64'd0);
        pulse_done();
        chk("R6 real done", 64'(reg_rd_data), 64'd1);
        chk("R6 err", 64'(proto_err), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule